// File: doc/BRIEF.md
# Clock Source Guard with Gear Divider

This block governs where a small controller's main clock comes from. Software writes enable bits for a fast and a slow oscillator, a bit that picks which of the two drives the main clock, and a bit that gives the fast oscillator's pins either to the oscillator or to general-purpose I/O. Every write to the control register is checked before it lands. If the new settings would stop the clock that is running, stop every oscillator, or turn on the fast oscillator while its pins are assigned elsewhere, the write is dropped. The block then drives an internal system reset and returns all of its settings to their defaults.

The fast clock passes through a gear that divides it by 1, 2, 4 or 8. A new ratio is carried into the fast clock domain through a synchroniser and is loaded only at a gear period boundary. The period that follows a change is therefore never shorter than both the old and the new period. A break-before-make handshake moves the main clock between the geared fast clock and the slow clock. Each side gates its clock on its own falling edge and opens only once the synchronised state of the other side shows it is off. A read-only status bit shows which source is actually driving the main clock, so software can poll it until a switch is complete.

Top module: `sysclk_guard`

## Requirements
- R1: After power-on reset the control register reads 5'b01001 at address 0 (bit0 fast enable = 1, bit1 slow enable = 0, bit2 source select = 0 meaning fast, bit3 pin ownership = 1 meaning oscillator, bit4 active-source status = 0 meaning fast). The gear field at address 1 (bits 1:0) reads 0, and the system reset output is high.
- R2: A control write that clears both oscillator enables drives the system reset output low at the edge that would have stored it.
- R3: A control write that leaves the slow clock selected or running with the slow enable cleared causes a system reset.
- R4: A control write that leaves the fast clock selected or running with the fast enable cleared causes a system reset.
- R5: A control write that sets the fast enable while pin ownership is 0 (port mode) causes a system reset.
- R6: While the slow clock still drives the main clock, a write that selects the fast clock and also clears the slow enable causes a system reset. The reset is held until the slow clock has been gated off.
- R7: A system reset lasts at least RST_CYCLES reference-clock cycles. It leaves the control register at 5'b01001 with the gear field at 0, and register writes made during it have no effect.
- R8: Gear code 0, 1, 2 or 3 makes the main clock period 1, 2, 4 or 8 fast-clock periods while the fast clock is the source.
- R9: After a gear write, no main clock period is shorter than the smaller of the old and new periods. The new period holds from the third full period onward.
- R10: The main clock carries no high or low pulse shorter than half a fast-clock period, and the two source gates are never open at the same time.
- R11: The status bit (address 0, bit 4) reads 1 only once the slow clock drives the main clock, and 0 once the fast clock does.
- R12: Legal combinations, such as the slow clock as source with the fast oscillator off and its pins in port mode, never cause a system reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock for the register side |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hf_clk | input | 1 | Fast oscillator clock |
| lf_clk | input | 1 | Slow oscillator clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 gear |
| wr_data | input | 4 | Write data |
| rd_data | output | 5 | Read data for the selected register |
| hf_osc_en | output | 1 | Fast oscillator enable |
| lf_osc_en | output | 1 | Slow oscillator enable |
| osc_pins_en | output | 1 | Fast oscillator pins given to the oscillator |
| main_clk | output | 1 | Selected and geared main clock |
| sys_rst_n | output | 1 | Internal system reset, active low |

## Verification
The bench goes after each of the four forbidden combinations and after the stale switch, in which the slow enable is cleared while the slow clock is still running. A guard that checked only the requested source would let that write through and leave the main clock without a live oscillator. It measures the period of the main clock across gear changes in both directions, including 8 to 1 and 1 to 8. A divider that reloaded at once, or sampled a half-synchronised code, would emit a runt period. It also watches every main-clock edge for narrow pulses while switching sources. A mux that opened one gate before the other had closed would show a short pulse or an overlap. Reset length, writes made during reset, and the gear field's return to zero are also checked, because a guard that only pulsed reset would leave the bad setting in place.

// File: rtl/sckg_pkg.sv
`timescale 1ns/1ps
package sckg_pkg;
  localparam int CTRL_W = 4;
  localparam int RD_W   = CTRL_W + 1;
  localparam int GEAR_W = 2;
  localparam int GEAR_MAX_DIV = 1 << ((1 << GEAR_W) - 1);
  localparam int GEAR_CNT_W = $clog2(GEAR_MAX_DIV);
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_GEAR = 1'b1;

  typedef enum logic [GEAR_W-1:0] {
    GEAR_DIV1 = 2'd0,
    GEAR_DIV2 = 2'd1,
    GEAR_DIV4 = 2'd2,
    GEAR_DIV8 = 2'd3
  } gear_e;

  // packed bit 0 is hf_en, bit 3 is pin_osc
  typedef struct packed {
    logic pin_osc;
    logic src_lf;
    logic lf_en;
    logic hf_en;
  } ctrl_t;

  localparam ctrl_t CTRL_DEFAULT = '{pin_osc: 1'b1, src_lf: 1'b0, lf_en: 1'b0, hf_en: 1'b1};
endpackage

// File: rtl/sckg_sync.sv
`timescale 1ns/1ps
module sckg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sckg_regs.sv
`timescale 1ns/1ps
module sckg_regs
  import sckg_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              hf_act,
  input  logic              lf_act,
  output ctrl_t             ctrl_o,
  output gear_e             gear_o,
  output logic [RD_W-1:0]   rd_data,
  output logic              sys_rst_n_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  ctrl_t            ctrl_q, ctrl_d, cand, wr_ctrl;
  gear_e            gear_q, gear_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             in_reset, wr_ok, illegal;
  logic             hf_in_use, lf_in_use;

  assign wr_ctrl = ctrl_t'(wr_data);

  // Next state: the candidate value is checked before it may land.
  always_comb begin
    in_reset = (cnt_q != '0);
    wr_ok    = wr_en && !in_reset;
    cand     = ctrl_q;
    if (wr_ok && addr == ADDR_CTRL) cand = wr_ctrl;
    hf_in_use = !cand.src_lf || hf_act;
    lf_in_use =  cand.src_lf || lf_act;
    illegal = (!cand.hf_en && !cand.lf_en)
           || (lf_in_use && !cand.lf_en)
           || (hf_in_use && !cand.hf_en)
           || (cand.hf_en && !cand.pin_osc);
    ctrl_d = cand;
    gear_d = gear_q;
    if (wr_ok && addr == ADDR_GEAR) gear_d = gear_e'(wr_data[GEAR_W-1:0]);
    cnt_d = in_reset ? cnt_q - 1'b1 : '0;
    if (illegal) begin
      ctrl_d = CTRL_DEFAULT;
      gear_d = GEAR_DIV1;
      cnt_d  = CNT_W'(RST_CYCLES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_DEFAULT;
      gear_q <= GEAR_DIV1;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      gear_q <= gear_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    if (addr == ADDR_CTRL) rd_data = {lf_act, ctrl_q};
    else                   rd_data = {{(RD_W-GEAR_W){1'b0}}, gear_q};
  end

  assign ctrl_o      = ctrl_q;
  assign gear_o      = gear_q;
  assign sys_rst_n_o = !in_reset;

  a_r2_both_off_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == ADDR_CTRL && !wr_ctrl.hf_en && !wr_ctrl.lf_en) |=> !sys_rst_n_o);
  a_r3_slow_off_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == ADDR_CTRL && wr_ctrl.src_lf && !wr_ctrl.lf_en) |=> !sys_rst_n_o);
  a_r4_fast_off_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == ADDR_CTRL && !wr_ctrl.src_lf && !wr_ctrl.hf_en) |=> !sys_rst_n_o);
  a_r5_pin_conflict_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == ADDR_CTRL && wr_ctrl.hf_en && !wr_ctrl.pin_osc) |=> !sys_rst_n_o);
  a_r6_stale_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (lf_act && !ctrl_q.lf_en) |-> !sys_rst_n_o);
  a_r7_defaults_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n_o |-> (ctrl_q == CTRL_DEFAULT && gear_q == GEAR_DIV1));
  a_r7_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst_n_o && !illegal) |=> ($stable(ctrl_q) && $stable(gear_q)));
endmodule

// File: rtl/sckg_gear.sv
`timescale 1ns/1ps
module sckg_gear
  import sckg_pkg::*;
(
  input  logic  hf_clk,
  input  logic  hf_rst_n,
  input  gear_e gear_sel,
  output logic  gclk
);
  logic [GEAR_CNT_W-1:0] cnt_q, cnt_d;
  logic                  at_edge;
  logic                  gate_q;

  // New ratio is loaded only when the running period ends.
  always_comb begin
    at_edge = (cnt_q == '0);
    if (at_edge) cnt_d = GEAR_CNT_W'((1 << gear_sel) - 1);
    else         cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge hf_clk or negedge hf_rst_n) begin
    if (!hf_rst_n) cnt_q <= '0;
    else           cnt_q <= cnt_d;
  end

  // Gate changes only while hf_clk is low, so gclk has full-width pulses.
  always_ff @(negedge hf_clk or negedge hf_rst_n) begin
    if (!hf_rst_n) gate_q <= 1'b0;
    else           gate_q <= at_edge;
  end

  assign gclk = hf_clk & gate_q;

  a_r9_load_only_at_boundary: assert property (@(posedge hf_clk) disable iff (!hf_rst_n)
    (cnt_q != '0) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/sckg_srcmux.sv
`timescale 1ns/1ps
module sckg_srcmux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic hf_clk,
  input  logic hf_rst_n,
  input  logic lf_clk,
  input  logic lf_rst_n,
  input  logic gclk,
  input  logic want_lf,
  output logic hf_on,
  output logic lf_on,
  output logic main_clk
);
  logic want_lf_h, lf_on_h, want_lf_l, hf_on_l;

  sckg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_h (
    .clk(hf_clk), .rst_n(hf_rst_n), .d({want_lf, lf_on}), .q({want_lf_h, lf_on_h}));
  sckg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_l (
    .clk(lf_clk), .rst_n(lf_rst_n), .d({want_lf, hf_on}), .q({want_lf_l, hf_on_l}));

  // Each gate opens only when the other side is seen closed.
  always_ff @(negedge hf_clk or negedge hf_rst_n) begin
    if (!hf_rst_n) hf_on <= 1'b0;
    else           hf_on <= !want_lf_h && !lf_on_h;
  end

  always_ff @(negedge lf_clk or negedge lf_rst_n) begin
    if (!lf_rst_n) lf_on <= 1'b0;
    else           lf_on <= want_lf_l && !hf_on_l;
  end

  assign main_clk = (gclk & hf_on) | (lf_clk & lf_on);

  a_r10_gates_exclusive: assert property (@(posedge hf_clk) disable iff (!hf_rst_n || !lf_rst_n)
    !(hf_on && lf_on));
endmodule

// File: rtl/sysclk_guard.sv
`timescale 1ns/1ps
module sysclk_guard
  import sckg_pkg::*;
#(
  parameter int RST_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hf_clk,
  input  logic              lf_clk,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [RD_W-1:0]   rd_data,
  output logic              hf_osc_en,
  output logic              lf_osc_en,
  output logic              osc_pins_en,
  output logic              main_clk,
  output logic              sys_rst_n
);
  logic  c_rst_n, h_rst_n, l_rst_n;
  logic  hf_on, lf_on, hf_act, lf_act, gclk;
  ctrl_t ctrl;
  gear_e gear_c;
  logic [GEAR_W-1:0] gear_h;

  sckg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_c (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(c_rst_n));
  sckg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_h (
    .clk(hf_clk), .rst_n(rst_n), .d(1'b1), .q(h_rst_n));
  sckg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_l (
    .clk(lf_clk), .rst_n(rst_n), .d(1'b1), .q(l_rst_n));

  sckg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_act_c (
    .clk(clk), .rst_n(c_rst_n), .d({hf_on, lf_on}), .q({hf_act, lf_act}));
  sckg_sync #(.WIDTH(GEAR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_gear_h (
    .clk(hf_clk), .rst_n(h_rst_n), .d(gear_c), .q(gear_h));

  sckg_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
    .clk(clk), .rst_n(c_rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .hf_act(hf_act), .lf_act(lf_act), .ctrl_o(ctrl), .gear_o(gear_c),
    .rd_data(rd_data), .sys_rst_n_o(sys_rst_n));

  sckg_gear u_gear (
    .hf_clk(hf_clk), .hf_rst_n(h_rst_n), .gear_sel(gear_e'(gear_h)), .gclk(gclk));

  sckg_srcmux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .hf_clk(hf_clk), .hf_rst_n(h_rst_n), .lf_clk(lf_clk), .lf_rst_n(l_rst_n),
    .gclk(gclk), .want_lf(ctrl.src_lf), .hf_on(hf_on), .lf_on(lf_on),
    .main_clk(main_clk));

  assign hf_osc_en   = ctrl.hf_en;
  assign lf_osc_en   = ctrl.lf_en;
  assign osc_pins_en = ctrl.pin_osc;
endmodule

// File: tb/test_sysclk_guard.sv
`timescale 1ns/1ps
module test_sysclk_guard;
  localparam realtime CLK_PERIOD = 10.0;
  localparam realtime HF_PERIOD  = 6.0;
  localparam realtime LF_PERIOD  = 50.0;
  localparam int      RST_CYC    = 4;
  localparam int      HF_PS      = 6000;
  localparam int      LF_PS      = 50000;

  logic clk = 1'b0, hf_clk = 1'b0, lf_clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, addr = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic [4:0] rd_data;
  logic hf_osc_en, lf_osc_en, osc_pins_en, main_clk, sys_rst_n;

  sysclk_guard #(.RST_CYCLES(RST_CYC)) i_sysclk_guard (
    .clk(clk), .rst_n(rst_n), .hf_clk(hf_clk), .lf_clk(lf_clk),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .hf_osc_en(hf_osc_en), .lf_osc_en(lf_osc_en), .osc_pins_en(osc_pins_en),
    .main_clk(main_clk), .sys_rst_n(sys_rst_n));

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(HF_PERIOD/2)  hf_clk = ~hf_clk;
  always #(LF_PERIOD/2)  lf_clk = ~lf_clk;

  int n_checks = 0, n_fail = 0, narrow = 0, trips = 0;
  bit mon_on = 1'b0;
  realtime last_edge = 0.0;

  always @(main_clk) begin
    if (mon_on && ($realtime - last_edge) < (HF_PERIOD/2 - 0.01)) narrow++;
    last_edge = $realtime;
  end

  always @(negedge sys_rst_n) if (rst_n) trips++;

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not complete (actual timeout, expected completion)");
    finish_run();
  end

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input string what, input int act, input int lim);
    n_checks++;
    if (act < lim) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lim);
    end
  endtask

  task automatic chk_near(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act > exp + 2 || act < exp - 2) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [3:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output int v);
    @(negedge clk);
    addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic gap_ps(output int g);
    realtime t0;
    @(posedge main_clk);
    t0 = $realtime;
    @(posedge main_clk);
    g = int'(($realtime - t0) * 1000.0);
  endtask

  task automatic wait_act(input bit v, input string req);
    int s = -1;
    for (int k = 0; k < 300; k++) begin
      rd(1'b0, s);
      if (((s >> 4) & 1) == int'(v)) break;
    end
    chk_eq(req, "status bit after switch", (s >> 4) & 1, int'(v));
    repeat (20) @(posedge clk);
  endtask

  // Expect a reset from the write just made; optionally write during it.
  task automatic expect_trip(input string req, input logic [3:0] d, input bit poke);
    int len = 0;
    int v;
    wr(1'b0, d);
    chk_eq(req, "reset low after bad write", int'(sys_rst_n), 0);
    if (poke) begin
      wr(1'b1, 4'h2);
      wr(1'b0, 4'hF);
      len = 2;
    end
    while (!sys_rst_n && len < 10000) begin
      len++;
      @(posedge clk);
      #1;
    end
    chk_ge("R7", "reset length in cycles", len, RST_CYC);
    rd(1'b0, v);
    chk_eq("R7", "control after reset", v & 15, 9);
    rd(1'b1, v);
    chk_eq("R7", "gear after reset", v, 0);
    repeat (20) @(posedge clk);
  endtask

  initial begin
    int v, g, cur, nxt, t0trips;
    int gaps [4];
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (30) @(posedge clk);

    // R1 reset state
    rd(1'b0, v);  chk_eq("R1", "control readback", v, 9);
    rd(1'b1, v);  chk_eq("R1", "gear readback", v, 0);
    chk_eq("R1", "system reset high", int'(sys_rst_n), 1);
    mon_on = 1'b1;

    // R8 base period
    gap_ps(g);  chk_near("R8", "div1 period ps", g, HF_PS);

    // R8/R9 directed then random gear changes
    cur = 0;
    for (int t = 0; t < 7; t++) begin
      if (t == 0)      nxt = 3;
      else if (t == 1) nxt = 0;
      else             nxt = int'($urandom % 4);
      wr(1'b1, 4'(nxt));
      for (int i = 0; i < 4; i++) gap_ps(gaps[i]);
      for (int i = 0; i < 3; i++)
        chk_ge("R9", "period after gear change ps", gaps[i], HF_PS * ((1 << cur) < (1 << nxt) ? (1 << cur) : (1 << nxt)) - 2);
      chk_near("R8", "settled gear period ps", gaps[3], HF_PS * (1 << nxt));
      cur = nxt;
    end

    // R11 / R12 legal switch to the slow clock
    t0trips = trips;
    wr(1'b0, 4'b1111);
    wait_act(1'b1, "R11");
    rd(1'b0, v);  chk_eq("R11", "readback in slow mode", v, 31);
    gap_ps(g);    chk_near("R10", "slow source period ps", g, LF_PS);
    wr(1'b0, 4'b0110);
    repeat (10) @(posedge clk);
    rd(1'b0, v);  chk_eq("R12", "fast off, pins as port", v, 22);
    wr(1'b0, 4'b1111);
    wr(1'b0, 4'b1011);
    wait_act(1'b0, "R11");
    gap_ps(g);    chk_near("R8", "geared period after return ps", g, HF_PS * (1 << cur));
    chk_eq("R12", "no reset during legal sequence", trips - t0trips, 0);

    // R6 stale switch
    wr(1'b0, 4'b1111);
    wait_act(1'b1, "R11");
    expect_trip("R6", 4'b1001, 1'b0);
    rd(1'b0, v);  chk_eq("R6", "status back on fast clock", (v >> 4) & 1, 0);

    // R2 both off, with writes during reset (R7)
    wr(1'b1, 4'h3);
    expect_trip("R2", 4'b1000, 1'b1);
    // R3, R4, R5
    expect_trip("R3", 4'b1101, 1'b0);
    expect_trip("R4", 4'b1010, 1'b0);
    expect_trip("R5", 4'b0011, 1'b0);

    gap_ps(g);  chk_near("R8", "div1 period after resets ps", g, HF_PS);
    chk_eq("R10", "narrow main clock pulses", narrow, 0);
    finish_run();
  end
endmodule